// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block tracks the reservation that a load-exclusive places on memory and decides whether the matching store-exclusive may complete. The reservation has two halves. The local half always applies. The global half applies only to shareable memory. A mark request records the reserved granule. A check request reports pass or fail one cycle later, or it reports an alignment fault. A clear port handles two cases: an explicit drop of the local half, and the address of every ordinary shareable store. That store address removes a global reservation that the store overlaps.

Reservations cover one aligned granule of 2^GRAN_LG bytes (8 by default). The physical address equals the virtual address. Size fields are log2 of the byte count: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is 8 bytes.

Top module: `excl_monitor`

## Requirements
- R1: After reset both halves are invalid, `res_vld` is 0, and any check fails until a mark has been made.
- R2: A mark with `mark_shr`=1 sets the local and global halves to the granule of `mark_addr`. A mark with `mark_shr`=0 sets only the local half and leaves the global half as it was. Marks are naturally aligned to `mark_size`.
- R3: A check passes when the local half matches. When `chk_shr`=1 the global half must match as well.
- R4: A half matches only when it is valid and `chk_addr` lies in the same aligned 8-byte granule as the marked address.
- R5: A passing check clears the local half and keeps the global half. A failing check changes nothing.
- R6: A check whose address is not a multiple of its size returns `res_fault`=1 and `res_pass`=0, and it leaves the state unchanged.
- R7: `clr_local` removes the local half.
- R8: A clear-by-address (`clr_addr_vld`) removes the global half if any byte from `clr_addr` to `clr_addr`+2^`clr_size`-1 lies in its granule. The local half is not affected.
- R9: Each check produces exactly one result, with `res_vld` high on the cycle after `chk_vld`. `res_vld` is low at all other times.
- R10: When a mark and a check arrive in the same cycle, the check is judged against the state before the mark. The new mark is in place afterwards. All clears take effect before the mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mark_vld | input | 1 | Mark request |
| mark_addr | input | AW | Mark address |
| mark_size | input | 2 | Mark size, log2 bytes |
| mark_shr | input | 1 | Mark location is shareable |
| chk_vld | input | 1 | Check request |
| chk_addr | input | AW | Check address |
| chk_size | input | 2 | Check size, log2 bytes |
| chk_shr | input | 1 | Check location is shareable |
| clr_local | input | 1 | Drop the local reservation |
| clr_addr_vld | input | 1 | Clear global reservation by address (shareable store) |
| clr_addr | input | AW | Store address |
| clr_size | input | 2 | Store size, log2 bytes |
| res_vld | output | 1 | Check result valid |
| res_pass | output | 1 | Check passed |
| res_fault | output | 1 | Check had an alignment fault |

## Verification
The bench aims at the asymmetry between the two halves:
- A non-shareable mark followed by a shareable check must fail. A design that set the global half on every mark would pass it.
- A re-mark after a pass must find the global half still present. A design that cleared both halves on a pass would fail that check.

Granule edges are tested with a check on the first byte of the next granule. Clear-by-address is tested with stores that touch the granule only through their last byte. A design that compared only the start address would leave that reservation alive. Same-cycle mark and check is tested in both directions: a design that let the mark win the check would pass a check it should fail. A misaligned check that still altered the state would make the following check fail.

// File: rtl/excl_monitor.sv
module excl_monitor #(
  parameter int AW      = 32,
  parameter int GRAN_LG = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mark_vld,
  input  logic [AW-1:0] mark_addr,
  input  logic [1:0]    mark_size,
  input  logic          mark_shr,
  input  logic          chk_vld,
  input  logic [AW-1:0] chk_addr,
  input  logic [1:0]    chk_size,
  input  logic          chk_shr,
  input  logic          clr_local,
  input  logic          clr_addr_vld,
  input  logic [AW-1:0] clr_addr,
  input  logic [1:0]    clr_size,
  output logic          res_vld,
  output logic          res_pass,
  output logic          res_fault
);
  localparam int TW = AW - GRAN_LG;

  logic          loc_v, glb_v;
  logic [TW-1:0] loc_tag, glb_tag;

  wire [AW-1:0] chk_span  = (AW'(1) << chk_size) - AW'(1);
  wire [AW-1:0] mark_span = (AW'(1) << mark_size) - AW'(1);
  wire [AW-1:0] st_last   = clr_addr + ((AW'(1) << clr_size) - AW'(1));

  wire [TW-1:0] chk_tag = chk_addr[AW-1:GRAN_LG];
  wire          chk_mis = |(chk_addr & chk_span);
  wire          loc_hit = loc_v && (loc_tag == chk_tag);
  wire          glb_hit = glb_v && (glb_tag == chk_tag);
  wire          chk_ok  = !chk_mis && loc_hit && (!chk_shr || glb_hit);
  wire          st_hit  = clr_addr_vld && glb_v &&
                          ((glb_tag == clr_addr[AW-1:GRAN_LG]) ||
                           (glb_tag == st_last[AW-1:GRAN_LG]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loc_v     <= 1'b0;
      glb_v     <= 1'b0;
      loc_tag   <= '0;
      glb_tag   <= '0;
      res_vld   <= 1'b0;
      res_pass  <= 1'b0;
      res_fault <= 1'b0;
    end else begin
      res_vld   <= chk_vld;
      res_pass  <= chk_vld && chk_ok;
      res_fault <= chk_vld && chk_mis;
      if ((chk_vld && chk_ok) || clr_local) loc_v <= 1'b0;
      if (st_hit) glb_v <= 1'b0;
      if (mark_vld) begin
        loc_v   <= 1'b1;
        loc_tag <= mark_addr[AW-1:GRAN_LG];
        if (mark_shr) begin
          glb_v   <= 1'b1;
          glb_tag <= mark_addr[AW-1:GRAN_LG];
        end
      end
    end
  end

  // R9
  res_follows_chk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_vld |=> res_vld);
  // R9
  res_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_vld |=> !res_vld);
  // R6
  fault_no_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_fault |-> res_vld && !res_pass);
  // R2
  mark_sets_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mark_vld && mark_shr |=> loc_v && glb_v);
  // R2
  mark_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mark_vld |-> (mark_addr & mark_span) == '0);
  // R5
  pass_drops_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_vld && !mark_vld && loc_hit && !chk_mis && (!chk_shr || glb_hit) |=> !loc_v && res_pass);
  // R7
  clear_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_local && !mark_vld |=> !loc_v);
endmodule

// File: tb/test_excl_monitor.sv
module test_excl_monitor;
  localparam int AW = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mark_vld = 0, mark_shr = 0, chk_vld = 0, chk_shr = 0, clr_local = 0, clr_addr_vld = 0;
  logic [AW-1:0] mark_addr = '0, chk_addr = '0, clr_addr = '0;
  logic [1:0] mark_size = '0, chk_size = '0, clr_size = '0;
  logic res_vld, res_pass, res_fault;

  int n_chk = 0, n_bad = 0;
  logic q_pass[$];
  logic q_fault[$];
  string q_tag[$];

  always #10 clk = ~clk;

  excl_monitor #(.AW(AW)) i_excl_monitor (.*);

  task automatic note(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
    mark_vld = 0; chk_vld = 0; clr_local = 0; clr_addr_vld = 0;
  endtask

  task automatic set_mark(input logic [AW-1:0] a, input logic [1:0] s, input logic sh);
    mark_vld = 1; mark_addr = a; mark_size = s; mark_shr = sh;
  endtask

  task automatic set_chk(input logic [AW-1:0] a, input logic [1:0] s, input logic sh,
                         input logic ep, input logic ef, input string tag);
    chk_vld = 1; chk_addr = a; chk_size = s; chk_shr = sh;
    q_pass.push_back(ep); q_fault.push_back(ef); q_tag.push_back(tag);
  endtask

  task automatic do_mark(input logic [AW-1:0] a, input logic [1:0] s, input logic sh);
    set_mark(a, s, sh); step();
  endtask

  task automatic do_chk(input logic [AW-1:0] a, input logic [1:0] s, input logic sh,
                        input logic ep, input logic ef, input string tag);
    set_chk(a, s, sh, ep, ef, tag); step();
  endtask

  task automatic do_st(input logic [AW-1:0] a, input logic [1:0] s);
    clr_addr_vld = 1; clr_addr = a; clr_size = s; step();
  endtask

  always @(posedge clk) begin
    #10;
    if (rst_n && res_vld) begin
      if (q_pass.size() == 0) begin
        note(0, "R9 unexpected res_vld", 1, 0);
      end else begin
        automatic logic ep = q_pass.pop_front();
        automatic logic ef = q_fault.pop_front();
        automatic string tg = q_tag.pop_front();
        note(res_pass == ep, {tg, " pass"}, res_pass, ep);
        note(res_fault == ef, {tg, " fault"}, res_fault, ef);
      end
    end
  end

  bit done = 0;
  initial begin
    #(20 * 20000);
    if (!done) begin
      note(0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #12;
    note(res_vld == 0, "R1 res_vld in reset", res_vld, 0);
    rst_n = 1;
    step();
    note(res_vld == 0, "R1 res_vld idle", res_vld, 0);
    do_chk(32'h100, 2, 0, 0, 0, "R1 check before mark");

    do_mark(32'h100, 2, 1);
    do_chk(32'h104, 2, 1, 1, 0, "R2 R3 R4 shareable pass");
    do_chk(32'h100, 2, 0, 0, 0, "R5 local cleared by pass");
    do_mark(32'h100, 2, 0);
    do_chk(32'h100, 2, 1, 1, 0, "R5 global kept after pass");

    do_mark(32'h200, 2, 0);
    do_chk(32'h200, 2, 1, 0, 0, "R2 nonshareable mark lacks global");
    do_chk(32'h200, 2, 0, 1, 0, "R5 R3 fail leaves local");

    do_mark(32'h300, 0, 0);
    do_chk(32'h308, 0, 0, 0, 0, "R4 next granule");
    do_chk(32'h307, 0, 0, 1, 0, "R4 last byte of granule");

    do_mark(32'h400, 2, 0);
    do_chk(32'h402, 2, 0, 0, 1, "R6 misaligned");
    do_chk(32'h400, 2, 0, 1, 0, "R6 state unchanged");

    do_mark(32'h500, 3, 0);
    clr_local = 1; step();
    do_chk(32'h500, 3, 0, 0, 0, "R7 clear local");

    do_mark(32'h600, 3, 1);
    do_st(32'h607, 1);
    do_chk(32'h600, 3, 1, 0, 0, "R8 store start in granule");
    do_chk(32'h600, 3, 0, 1, 0, "R8 local survives store");
    do_mark(32'h600, 3, 1);
    do_st(32'h5FE, 1);
    do_chk(32'h600, 3, 1, 1, 0, "R8 store outside granule");
    do_mark(32'h600, 3, 1);
    do_st(32'h5FF, 1);
    do_chk(32'h600, 3, 1, 0, 0, "R8 store last byte in granule");

    set_mark(32'h700, 2, 0); set_chk(32'h700, 2, 0, 0, 0, "R10 check sees old state"); step();
    do_chk(32'h700, 2, 0, 1, 0, "R10 mark in place after");
    do_mark(32'h800, 2, 0);
    set_mark(32'h900, 2, 0); set_chk(32'h800, 2, 0, 1, 0, "R10 check passes on old"); step();
    do_chk(32'h900, 2, 0, 1, 0, "R10 mark wins over pass clear");

    repeat (4) step();
    note(q_pass.size() == 0, "R9 every check answered", q_pass.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule